// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Controller

This block drives a pair of complementary system resets from a synchronous supply-good flag, a software watchdog strobe and two mode controls. After supply-good goes true, reset stays asserted for a programmable hold time so that the supply and the processor can settle. Once reset releases, a watchdog counter runs. Software must toggle the strobe low at intervals shorter than the watchdog period. If it does not, the counter expires and the block issues a fresh reset pulse.

The watchdog can be turned off in three ways: a strobe-enable input, a low supply, and the combination of mode select high with a secondary-monitor-low flag. With mode select high and that flag set, each strobe falling edge returns a one-cycle interrupt pulse. Software can use this echo to confirm which voltage band the supply is in. The interrupt also pulses once each time supply-good rises. The analog monitoring is done elsewhere, and its results arrive here as clocked flags. Every duration is a parameter counted in clock cycles.

Top module: `sup_reset_wdog`

## Requirements
- R1: While `rst` is high, `reset_hi` is 1 and `nmi_pulse` is 0. When `supply_ok` is sampled 0 at a clock edge, `reset_hi` is 1 after that edge.
- R2: `supply_ok` is first sampled 1 at edge e0, after being 0. `reset_hi` stays 1 up to and including edge e0+HOLD_TICKS-1 and falls at edge e0+HOLD_TICKS.
- R3: `reset_lo` is always the inverse of `reset_hi`.
- R4: With no strobe and the watchdog enabled, `reset_hi` rises exactly WDOG_TICKS edges after the edge at which it fell. The watchdog does not count while reset is active.
- R5: `strobe_n` passes through a two-flop synchronizer. If `strobe_n` is first sampled low at edge k, the watchdog count clears at edge k+2. The next expiry then falls at edge k+2+WDOG_TICKS, so strobing at every WDOG_TICKS cycles or faster never expires.
- R6: A watchdog expiry holds `reset_hi` at 1 for HOLD_TICKS+1 cycles. The watchdog then restarts from zero and, without strobes, expires again WDOG_TICKS edges after the release.
- R7: With `mode_sel`=1 and `aux_low`=1, the watchdog is held cleared. Once `aux_low` drops, expiry comes WDOG_TICKS edges later. With `mode_sel`=0, `aux_low` has no effect on the watchdog.
- R8: With `strobe_en`=0, the watchdog is held cleared and never expires.
- R9: With `mode_sel`=1 and `aux_low`=1, a strobe first sampled low at edge k gives `nmi_pulse`=1 for exactly the cycle after edge k+2. With either control at 0, a strobe gives no pulse.
- R10: `supply_ok` sampled 1 at edge e0, after being 0 at the previous edge, gives `nmi_pulse`=1 for the one cycle after e0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Main supply in tolerance (synchronous flag) |
| strobe_n | input | 1 | Watchdog strobe, falling edge kicks (asynchronous) |
| strobe_en | input | 1 | Strobe connected; 0 disables the watchdog |
| mode_sel | input | 1 | 1 lets `aux_low` gate the watchdog and enable strobe echo |
| aux_low | input | 1 | Secondary monitor below its threshold |
| reset_hi | output | 1 | Active-high system reset |
| reset_lo | output | 1 | Active-low system reset |
| nmi_pulse | output | 1 | One-cycle interrupt pulse |

## Verification
The bench builds the block with HOLD_TICKS=5 and WDOG_TICKS=12. At these values every hold and expiry window can be walked cycle by cycle, and every edge can be compared against its exact expected count. The small watchdog period also makes it cheap to sweep the strobe interval over every value from 2 to WDOG_TICKS+3. This covers each period that keeps the system alive and the first few that must expire, so the exact expiry edge is checked on both sides of the boundary.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic {
        ST_HOLD = 1'b0,
        ST_RUN  = 1'b1
    } sup_state_e;

    typedef struct packed {
        logic run;
        logic kick;
    } wd_ctrl_t;

    function automatic logic wd_gated(input logic mode_sel, input logic aux_low);
        return mode_sel && aux_low;
    endfunction

endpackage

// File: rtl/sup_strobe_sync.sv
module sup_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_n,
    output logic fall
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-1:0], strobe_n};
    end

    assign fall = chain[STAGES] & ~chain[STAGES-1];
endmodule

// File: rtl/sup_hold_ctrl.sv
module sup_hold_ctrl
    import sup_pkg::*;
#(
    parameter int HOLD_TICKS = 25000
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok,
    input  logic wd_expire,
    output logic in_reset
);
    localparam int HW = $clog2(HOLD_TICKS + 1);
    localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_TICKS);

    sup_state_e     state;
    logic [HW-1:0]  hold_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_HOLD;
            hold_cnt <= '0;
        end else if (!supply_ok) begin
            state    <= ST_HOLD;
            hold_cnt <= '0;
        end else begin
            case (state)
                ST_HOLD: begin
                    if (hold_cnt == HOLD_LAST) begin
                        state    <= ST_RUN;
                        hold_cnt <= '0;
                    end else begin
                        hold_cnt <= hold_cnt + 1'b1;
                    end
                end
                default: begin
                    if (wd_expire) begin
                        state    <= ST_HOLD;
                        hold_cnt <= '0;
                    end
                end
            endcase
        end
    end

    assign in_reset = (state == ST_HOLD);
endmodule

// File: rtl/sup_wdog.sv
module sup_wdog
    import sup_pkg::*;
#(
    parameter int WDOG_TICKS = 400000
) (
    input  logic clk,
    input  logic rst,
    input  logic in_reset,
    input  logic supply_ok,
    input  logic strobe_en,
    input  logic mode_sel,
    input  logic aux_low,
    input  logic kick,
    output logic expire
);
    localparam int WW = (WDOG_TICKS > 2) ? $clog2(WDOG_TICKS) : 1;
    localparam logic [WW-1:0] WD_LAST = WW'(WDOG_TICKS - 1);

    wd_ctrl_t       ctl;
    logic [WW-1:0]  wd_cnt;

    always_comb begin
        ctl.run  = !in_reset && supply_ok && strobe_en && !wd_gated(mode_sel, aux_low);
        ctl.kick = kick;
    end

    always_ff @(posedge clk) begin
        if (rst || !ctl.run || ctl.kick) wd_cnt <= '0;
        else if (wd_cnt == WD_LAST)      wd_cnt <= '0;
        else                             wd_cnt <= wd_cnt + 1'b1;
    end

    assign expire = ctl.run && !ctl.kick && (wd_cnt == WD_LAST);
endmodule

// File: rtl/sup_nmi_gen.sv
module sup_nmi_gen
    import sup_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic supply_ok,
    input  logic fall,
    input  logic mode_sel,
    input  logic aux_low,
    output logic nmi
);
    logic supply_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            supply_q <= 1'b1;
            nmi      <= 1'b0;
        end else begin
            supply_q <= supply_ok;
            nmi      <= (fall && wd_gated(mode_sel, aux_low)) || (supply_ok && !supply_q);
        end
    end
endmodule

// File: rtl/sup_reset_wdog.sv
module sup_reset_wdog #(
    parameter int HOLD_TICKS = 25000,
    parameter int WDOG_TICKS = 400000
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok,
    input  logic strobe_n,
    input  logic strobe_en,
    input  logic mode_sel,
    input  logic aux_low,
    output logic reset_hi,
    output logic reset_lo,
    output logic nmi_pulse
);
    logic fall;
    logic in_reset;
    logic wd_expire;

    sup_strobe_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .strobe_n(strobe_n), .fall(fall)
    );

    sup_hold_ctrl #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
        .clk(clk), .rst(rst), .supply_ok(supply_ok),
        .wd_expire(wd_expire), .in_reset(in_reset)
    );

    sup_wdog #(.WDOG_TICKS(WDOG_TICKS)) u_wdog (
        .clk(clk), .rst(rst), .in_reset(in_reset), .supply_ok(supply_ok),
        .strobe_en(strobe_en), .mode_sel(mode_sel), .aux_low(aux_low),
        .kick(fall), .expire(wd_expire)
    );

    sup_nmi_gen u_nmi (
        .clk(clk), .rst(rst), .supply_ok(supply_ok), .fall(fall),
        .mode_sel(mode_sel), .aux_low(aux_low), .nmi(nmi_pulse)
    );

    assign reset_hi = in_reset;
    assign reset_lo = ~in_reset;
endmodule

// File: rtl/sup_reset_wdog_chk.sv
module sup_reset_wdog_chk #(
    parameter int HOLD_TICKS = 25000,
    parameter int WDOG_TICKS = 400000
) (
    input logic clk,
    input logic rst,
    input logic supply_ok,
    input logic strobe_en,
    input logic mode_sel,
    input logic aux_low,
    input logic reset_hi,
    input logic nmi_pulse
);
    logic [31:0] hi_cnt;
    logic [31:0] lo_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt <= '0;
            lo_cnt <= '0;
        end else begin
            hi_cnt <= (reset_hi && supply_ok) ? ((hi_cnt == '1) ? hi_cnt : hi_cnt + 1) : '0;
            lo_cnt <= (!reset_hi) ? ((lo_cnt == '1) ? lo_cnt : lo_cnt + 1) : '0;
        end
    end

    assert_supply_low_R1: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |=> reset_hi);

    assert_hold_min_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(reset_hi) |-> hi_cnt >= 32'(HOLD_TICKS));

    assert_wd_window_R4: assert property (@(posedge clk) disable iff (rst)
        ($rose(reset_hi) && $past(supply_ok)) |-> lo_cnt >= 32'(WDOG_TICKS));

    // R7 and R8: an expiry needs the strobe connected and no aux gating
    assert_wd_gate_R7: assert property (@(posedge clk) disable iff (rst)
        ($rose(reset_hi) && $past(supply_ok)) |-> ($past(strobe_en) && !$past(mode_sel && aux_low)));

    // R9 and R10: every interrupt pulse has a qualifying cause
    assert_nmi_cause_R9: assert property (@(posedge clk) disable iff (rst)
        nmi_pulse |-> ($past(mode_sel && aux_low) || ($past(supply_ok) && !$past(supply_ok, 2))));
endmodule

bind sup_reset_wdog sup_reset_wdog_chk #(
    .HOLD_TICKS(HOLD_TICKS),
    .WDOG_TICKS(WDOG_TICKS)
) u_chk (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .strobe_en(strobe_en),
    .mode_sel(mode_sel), .aux_low(aux_low), .reset_hi(reset_hi),
    .nmi_pulse(nmi_pulse)
);

// File: tb/sup_reset_wdog_bench.sv
module sup_reset_wdog_bench;
    localparam int H = 5;
    localparam int W = 12;

    logic clk = 1'b0;
    logic rst, supply_ok, strobe_n, strobe_en, mode_sel, aux_low;
    logic reset_hi, reset_lo, nmi_pulse;
    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    sup_reset_wdog #(.HOLD_TICKS(H), .WDOG_TICKS(W)) u_sup_reset_wdog (
        .clk(clk), .rst(rst), .supply_ok(supply_ok), .strobe_n(strobe_n),
        .strobe_en(strobe_en), .mode_sel(mode_sel), .aux_low(aux_low),
        .reset_hi(reset_hi), .reset_lo(reset_lo), .nmi_pulse(nmi_pulse)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_rst(input string tag, input logic exp);
        chk(tag, reset_hi, exp);
        chk("R3", reset_lo, ~exp);
    endtask

    task automatic power_up(input bit verify);
        supply_ok = 1'b0;
        repeat (2) @(negedge clk);
        supply_ok = 1'b1;
        for (int n = 1; n <= H + 1; n++) begin
            @(negedge clk);
            if (verify) begin
                chk_rst("R2", n <= H);
                chk("R10", nmi_pulse, n == 1);
            end
        end
    endtask

    task automatic wd_expect(input string tag, input int rise_at, input int limit);
        for (int m = 1; m <= limit; m++) begin
            logic e;
            @(negedge clk);
            e = (rise_at != 0) && (m >= rise_at);
            chk_rst(tag, e);
            if (e) break;
        end
    endtask

    task automatic strobe_once();
        strobe_n = 1'b0;
        @(negedge clk);
        strobe_n = 1'b1;
    endtask

    initial begin
        rst = 1'b1; supply_ok = 1'b0; strobe_n = 1'b1;
        strobe_en = 1'b1; mode_sel = 1'b0; aux_low = 1'b0;
        repeat (3) @(negedge clk);
        chk_rst("R1", 1'b1);
        chk("R1", nmi_pulse, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        chk_rst("R1", 1'b1);

        // R2, R10 power-up hold; then R4 expiry and R6 pulse width / restart
        power_up(1);
        wd_expect("R4", W, W);
        for (int j = 1; j <= H + 1; j++) begin
            @(negedge clk);
            chk_rst("R6", j <= H);
        end
        wd_expect("R6", W, W);

        // R5 strobe period sweep
        for (int p = 2; p <= W + 3; p++) begin
            power_up(0);
            for (int n = 0; n <= 3 * W; n++) begin
                logic e;
                strobe_n = (n % p == 0) ? 1'b0 : 1'b1;
                @(negedge clk);
                e = (p > W) && (n >= W + 2);
                chk_rst("R5", e);
                if (e) break;
            end
            strobe_n = 1'b1;
        end

        // R7 gated by aux in mode 1; R9 echo
        mode_sel = 1'b1; aux_low = 1'b1;
        power_up(0);
        wd_expect("R7", 0, 3 * W);
        strobe_n = 1'b0;
        @(negedge clk); chk("R9", nmi_pulse, 1'b0);
        strobe_n = 1'b1;
        @(negedge clk); chk("R9", nmi_pulse, 1'b0);
        @(negedge clk); chk("R9", nmi_pulse, 1'b1);
        @(negedge clk); chk("R9", nmi_pulse, 1'b0);
        aux_low = 1'b0;
        wd_expect("R7", W, W);

        // R7 mode 0 ignores aux
        mode_sel = 1'b0; aux_low = 1'b1;
        power_up(0);
        wd_expect("R7", W, W);

        // R8 strobe disabled; R9 negative cases; R1 supply drop
        strobe_en = 1'b0;
        power_up(0);
        wd_expect("R8", 0, 3 * W);
        strobe_once();
        repeat (3) begin @(negedge clk); chk("R9", nmi_pulse, 1'b0); end
        mode_sel = 1'b1; aux_low = 1'b0;
        strobe_once();
        repeat (3) begin @(negedge clk); chk("R9", nmi_pulse, 1'b0); end
        chk_rst("R8", 1'b0);
        supply_ok = 1'b0;
        @(negedge clk);
        chk_rst("R1", 1'b1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog timeout actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule